// File: doc/BRIEF.md
# Peripheral Frame Write-Protection Unit

This block keeps one write-protect flag for each of 64 peripheral memory frames and decides, for every peripheral access, whether it may proceed. Software changes the flags through a small 32-bit register bus that carries a privilege indicator. Each word of flags can be reached at two aliased addresses. One address sets the bits written as 1 and the other clears them. Both addresses read back the same live state.

The access side is purely combinational. The fabric presents a frame index, a read/write flag and a privilege flag. The block raises `acc_deny` only when a user-mode master tries to write a frame that is protected. Reads are always allowed, and privileged masters may always write. A parameter mask lists which frames have a peripheral behind them. Bits outside that mask never hold state and always read as zero.

Top module: `frame_guard`

## Requirements
- R1: After reset every protection bit is 0. All four register addresses read 0 and no access is denied.
- R2: A privileged register write to 0x00 (frames 0–31, bit n = frame n) or 0x04 (frames 32–63, bit n = frame 32+n) sets each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R3: A privileged register write to 0x10 (frames 0–31) or 0x14 (frames 32–63) clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: The set address and the clear address of the same word, 0x00/0x10 and 0x04/0x14, both read back the current flags of that word. `reg_rdata` is combinational from `reg_addr`.
- R5: A register write with `reg_priv` = 0 changes no flag.
- R6: The implemented-frame mask `IMPL_MASK` defaults to 0xF0FF_FFFF_7FFF_FFFE, so frames 0, 31 and 56–59 are not implemented. Those bits always read 0, and writes to them have no effect.
- R7: `acc_deny` is 1 exactly when `acc_valid`, `acc_write` and not `acc_priv` all hold and the flag of `acc_frame` is 1. Reads and privileged writes are never denied.
- R8: A register write changes the flags at the next rising clock edge. An access presented in the same cycle as the write is judged on the flags as they were before that write.
- R9: A register address other than 0x00, 0x04, 0x10 or 0x14 reads 0, and a write to it changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_priv | input | 1 | Register access comes from a privileged master |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| acc_valid | input | 1 | A peripheral access is presented |
| acc_frame | input | 6 | Frame index of the access |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access comes from a privileged master |
| acc_deny | output | 1 | Access must be blocked |

## Verification
The bench targets several ways a design can go wrong. A design that gates clears on privilege but forgets to gate sets would let a user write to 0x00 raise flags. A design that ignores the mask would show frames 0, 31 and 56–59 reading 1 after an all-ones set. A design that decodes only address bit 2 would alias unmapped addresses onto live words. A design that judges accesses on the new flags would deny an access in the very cycle it is being protected. Random mixes of set, clear, user writes, unmapped addresses and accesses run against a bench model, together with directed all-ones, cross-word and same-cycle cases.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned ADDR_W   = 5;
    localparam int unsigned WSEL_W   = 2;
    localparam int unsigned MAX_WORDS = 4;

    // Decoded view of a register address
    typedef struct packed {
        logic              hit;
        logic              clr;
        logic [WSEL_W-1:0] word;
    } reg_sel_t;
endpackage

// File: rtl/fg_decode.sv
module fg_decode
    import fg_pkg::*;
#(
    parameter int unsigned WORDS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    // Bit 4 picks the clear bank; bits 3:2 pick the word; bits 1:0 must be 0.
    always_comb begin
        sel.clr  = addr[4];
        sel.word = addr[3:2];
        sel.hit  = (addr[1:0] == 2'b00) && ({1'b0, addr[3:2]} < 3'(WORDS));
    end
endmodule

// File: rtl/fg_state.sv
module fg_state
    import fg_pkg::*;
#(
    parameter int unsigned   NUM_FRAMES = 64,
    parameter logic [63:0]   IMPL_MASK  = 64'hF0FF_FFFF_7FFF_FFFE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_go,
    input  reg_sel_t              sel,
    input  logic [WORD_W-1:0]     wdata,
    output logic [NUM_FRAMES-1:0] prot_q
);
    localparam int unsigned WORDS = NUM_FRAMES / WORD_W;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [WORD_W-1:0] M = IMPL_MASK[g*WORD_W +: WORD_W];
        logic [WORD_W-1:0] q;
        logic              mine;

        assign mine = wr_go && sel.hit && (sel.word == WSEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (mine) begin
                if (sel.clr) q <= (q & ~wdata) & M;
                else         q <= (q |  wdata) & M;
            end
        end

        assign prot_q[g*WORD_W +: WORD_W] = q;
    end
endmodule

// File: rtl/fg_access.sv
module fg_access #(
    parameter int unsigned NUM_FRAMES = 64,
    localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES)
) (
    input  logic [NUM_FRAMES-1:0] prot_q,
    input  logic                  acc_valid,
    input  logic [FRAME_W-1:0]    acc_frame,
    input  logic                  acc_write,
    input  logic                  acc_priv,
    output logic                  acc_deny
);
    logic user_wr;
    always_comb begin
        user_wr  = acc_valid && acc_write && !acc_priv;
        acc_deny = user_wr && prot_q[acc_frame];
    end
endmodule

// File: rtl/frame_guard.sv
module frame_guard
    import fg_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = 64,
    parameter logic [63:0] IMPL_MASK  = 64'hF0FF_FFFF_7FFF_FFFE,
    localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES),
    localparam int unsigned WORDS     = NUM_FRAMES / WORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_priv,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               acc_valid,
    input  logic [FRAME_W-1:0] acc_frame,
    input  logic               acc_write,
    input  logic               acc_priv,
    output logic               acc_deny
);
    reg_sel_t              sel;
    logic [NUM_FRAMES-1:0] prot_q;

    fg_decode #(.WORDS(WORDS)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    fg_state #(.NUM_FRAMES(NUM_FRAMES), .IMPL_MASK(IMPL_MASK)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_go  (reg_we && reg_priv),
        .sel    (sel),
        .wdata  (reg_wdata),
        .prot_q (prot_q)
    );

    // Both banks view the same word
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (sel.hit && sel.word == WSEL_W'(i)) reg_rdata = prot_q[i*WORD_W +: WORD_W];
        end
    end

    fg_access #(.NUM_FRAMES(NUM_FRAMES)) u_acc (
        .prot_q    (prot_q),
        .acc_valid (acc_valid),
        .acc_frame (acc_frame),
        .acc_write (acc_write),
        .acc_priv  (acc_priv),
        .acc_deny  (acc_deny)
    );
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
    parameter int unsigned NUM_FRAMES = 64,
    parameter logic [63:0] IMPL_MASK  = 64'hF0FF_FFFF_7FFF_FFFE,
    localparam int unsigned FRAME_W   = $clog2(NUM_FRAMES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic                  reg_priv,
    input logic [4:0]            reg_addr,
    input logic [31:0]           reg_wdata,
    input logic [NUM_FRAMES-1:0] prot_q,
    input logic                  acc_valid,
    input logic [FRAME_W-1:0]    acc_frame,
    input logic                  acc_write,
    input logic                  acc_priv,
    input logic                  acc_deny
);
    logic [NUM_FRAMES-1:0] hole;
    assign hole = ~IMPL_MASK[NUM_FRAMES-1:0];

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> prot_q == '0); // R1

    AST_SET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_priv && reg_addr == 5'h00
        |=> prot_q[31:0] == (($past(prot_q[31:0]) | $past(reg_wdata)) & IMPL_MASK[31:0])); // R2

    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && reg_priv && reg_addr == 5'h10
        |=> (prot_q[31:0] & $past(reg_wdata)) == 32'h0); // R3

    AST_USER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && !reg_priv |=> prot_q == $past(prot_q)); // R5

    AST_HOLES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q & hole) == '0); // R6

    AST_DENY_ONLY_USER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_deny |-> acc_valid && acc_write && !acc_priv && prot_q[acc_frame]); // R7

    AST_READ_NEVER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |-> !acc_deny); // R7

    AST_IDLE_REG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(prot_q)); // R8
endmodule

bind frame_guard fg_checker #(.NUM_FRAMES(NUM_FRAMES), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_priv  (reg_priv),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .prot_q    (prot_q),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .acc_write (acc_write),
    .acc_priv  (acc_priv),
    .acc_deny  (acc_deny)
);

// File: tb/tb_frame_guard.sv
module tb_frame_guard;
    localparam logic [63:0] MASK = 64'hF0FF_FFFF_7FFF_FFFE;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_we = 0, reg_priv = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 0, acc_write = 0, acc_priv = 0;
    logic [5:0]  acc_frame = '0;
    logic        acc_deny;

    int n_chk = 0, n_bad = 0;
    logic [63:0] model = '0;
    bit done = 0;

    always #4 clk = ~clk;

    frame_guard #(.NUM_FRAMES(64), .IMPL_MASK(MASK)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_priv(reg_priv),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_deny(acc_deny)
    );

    function automatic bit mapped(logic [4:0] a);
        return a == 5'h00 || a == 5'h04 || a == 5'h10 || a == 5'h14;
    endfunction

    function automatic logic [31:0] exp_rd(logic [4:0] a);
        if (!mapped(a)) return 32'h0;
        return a[2] ? model[63:32] : model[31:0];
    endfunction

    function automatic bit exp_deny(bit v, logic [5:0] f, bit w, bit p);
        return v && w && !p && model[f];
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(string tag, bit we, bit pr, logic [4:0] a, logic [31:0] d,
                        bit av, logic [5:0] f, bit aw, bit ap);
        @(negedge clk);
        reg_we = we; reg_priv = pr; reg_addr = a; reg_wdata = d;
        acc_valid = av; acc_frame = f; acc_write = aw; acc_priv = ap;
        #1;
        chk(tag, "rdata", reg_rdata, exp_rd(a));
        chk(tag, "deny", {31'b0, acc_deny}, {31'b0, exp_deny(av, f, aw, ap)});
        @(posedge clk);
        if (we && pr && mapped(a)) begin
            if (a[4]) begin
                if (a[2]) model[63:32] = model[63:32] & ~d;
                else      model[31:0]  = model[31:0]  & ~d;
            end else begin
                if (a[2]) model[63:32] = model[63:32] | d;
                else      model[31:0]  = model[31:0]  | d;
            end
            model = model & MASK;
        end
    endtask

    task automatic rd(string tag, logic [4:0] a);
        step(tag, 0, 1, a, 32'h0, 0, 6'd0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rdata in reset", reg_rdata, 32'h0);
        rst_n = 1;
        // R1: reset state
        rd("R1", 5'h00); rd("R1", 5'h04); rd("R1", 5'h10); rd("R1", 5'h14);
        step("R1", 0, 0, 5'h00, 0, 1, 6'd5, 1, 0);
        // R5: user set ignored
        step("R5", 1, 0, 5'h00, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd("R5", 5'h00);
        // R2/R6: all-ones set, holes stay 0
        step("R2", 1, 1, 5'h00, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R6", 1, 1, 5'h04, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd("R6", 5'h00); rd("R6", 5'h04);
        // R4: alias reads
        rd("R4", 5'h10); rd("R4", 5'h14);
        // R9: unmapped reads and writes
        rd("R9", 5'h08); rd("R9", 5'h02); rd("R9", 5'h18);
        step("R9", 1, 1, 5'h18, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R9", 1, 1, 5'h11, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd("R9", 5'h00); rd("R9", 5'h04);
        // R7: decisions on protected frame 40
        step("R7", 0, 0, 5'h00, 0, 1, 6'd40, 1, 0);
        step("R7", 0, 0, 5'h00, 0, 1, 6'd40, 0, 0);
        step("R7", 0, 0, 5'h00, 0, 1, 6'd40, 1, 1);
        step("R7", 0, 0, 5'h00, 0, 0, 6'd40, 1, 0);
        step("R7", 0, 0, 5'h00, 0, 1, 6'd57, 1, 0);
        // R5: user clear ignored
        step("R5", 1, 0, 5'h14, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd("R5", 5'h04);
        // R3/R8: clear frame 40 with same-cycle user write still denied
        step("R8", 1, 1, 5'h14, 32'h0000_0100, 1, 6'd40, 1, 0);
        step("R8", 0, 0, 5'h00, 0, 1, 6'd40, 1, 0);
        rd("R3", 5'h04); rd("R3", 5'h14);
        // R8: protect frame 3 and access in the same cycle
        step("R3", 1, 1, 5'h10, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R8", 1, 1, 5'h00, 32'h0000_0008, 1, 6'd3, 1, 0);
        step("R8", 0, 0, 5'h00, 0, 1, 6'd3, 1, 0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] a;
            int r = $urandom_range(0, 9);
            a = (r < 8) ? ((r % 4 == 0) ? 5'h00 : (r % 4 == 1) ? 5'h04 :
                           (r % 4 == 2) ? 5'h10 : 5'h14) : 5'($urandom());
            step(mapped(a) ? (a[4] ? "R3" : "R2") : "R9",
                 $urandom_range(0, 1), $urandom_range(0, 9) < 7, a, $urandom(),
                 $urandom_range(0, 3) != 0, 6'($urandom()),
                 $urandom_range(0, 1), $urandom_range(0, 1));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule